// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A request carries the virtual address, whether the access is a write, whether it comes from user mode, and the control bits the translation depends on: paging enable, supervisor write protection, large-page enable and the directory base address. The walker reads the directory entry and, for a 4 KB page, the table entry after it. It checks access rights at each level and stores updated accessed and dirty bits back into the entries. It then returns one of two results: a physical address with a writable indication, or a page fault with an error code. The address of the last fault is kept in a register.

The walker handles one request at a time. Requests use a valid/ready handshake. Memory is reached through a single 32-bit port with request/acknowledge, and each acknowledged cycle completes one read or one write. The response is a one-cycle pulse on `rsp_valid`. A synchronous reset returns the walker to idle.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from the base address with its low 12 bits forced to zero, plus virtual address bits 31:22 times 4.
- R2: The table entry is read from the directory entry with its low 12 bits forced to zero, plus virtual address bits 21:12 times 4.
- R3: An entry whose present bit (bit 0) is clear ends the walk with a fault. No further memory access follows. The error code is {user, write, protection} in bits 2, 1 and 0, with the protection bit 0 here. The fault address register takes the virtual address and changes on no other response.
- R4: A user access faults with protection bit 1 when an entry on the path has its user bit (bit 2) clear. A user write also faults when an entry has its read/write bit (bit 1) clear.
- R5: A supervisor write faults with protection bit 1 only when write protection is on and an entry has its user bit set and its read/write bit clear. Otherwise supervisor accesses pass the rights check.
- R6: A directory entry with its large-page bit (bit 7) set, while large pages are enabled, ends the walk at the directory. The physical address is entry bits 31:22 followed by virtual address bits 21:0. When large pages are disabled, the same entry is used as a table pointer.
- R7: On a 4 KB walk, a directory entry whose accessed bit (bit 5) is clear is written back with that bit set, before the table entry is read. An entry whose accessed bit is already set is not written.
- R8: A table entry is written back with bit 5 set when its accessed bit was clear, or when a write finds its dirty bit (bit 6) clear. On a write the dirty bit is set in that write-back. A 4 KB translation returns the table entry bits 31:12 followed by virtual address bits 11:0.
- R9: On a 4 MB walk, the directory entry is written back only when its accessed bit was clear. That write-back also sets the dirty bit when the access is a write.
- R10: For a user access, the writable flag equals the final entry's read/write bit. For a supervisor access it is 1, unless write protection is on and the final entry is a user entry with read/write clear.
- R11: With paging disabled, the response comes in the cycle after acceptance. It returns the virtual address unchanged, with writable set, no fault and no memory access.
- R12: `req_ready` is high only while idle. `rsp_valid` is a single-cycle pulse. A memory request holds its address until it is acknowledged. After reset the walker is idle, with no memory request, no response and a fault address of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| cfg_pg_en | input | 1 | Paging enabled |
| cfg_wp | input | 1 | Supervisor write protection enabled |
| cfg_pse | input | 1 | Large pages enabled |
| cfg_base | input | 32 | Page directory base |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Result is a page fault |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_writable | output | 1 | Page may be written |
| rsp_err | output | 3 | Fault code {user, write, protection} |
| fault_addr | output | 32 | Virtual address of the last fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Entry write-back data |
| mem_ack | input | 1 | Access complete this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
Each memory access takes one cycle per acknowledge. A request accepted at an edge has its first memory access in the following cycle. The k-th access of the walk follows one cycle after the previous one. `rsp_valid` rises in the cycle after the last acknowledged access, or in the cycle after acceptance when no access is needed. The reference model in the bench first lists the expected accesses in order, together with the expected result. It then compares every cycle from acceptance to the return to idle against that list. The memory model acknowledges in every cycle, so a missing, extra or reordered access, or a result one cycle early or late, shows up as a miscompare.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [2:0] {
        W_IDLE,
        W_DIR_RD,
        W_DIR_WR,
        W_TBL_RD,
        W_TBL_WR,
        W_RESP
    } walk_st_e;

    localparam int E_PRES  = 0;
    localparam int E_RW    = 1;
    localparam int E_USER  = 2;
    localparam int E_ACC   = 5;
    localparam int E_DIRTY = 6;
    localparam int E_BIG   = 7;
endpackage

// File: rtl/pw_perm.sv
module pw_perm
    import pw_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic [EW-1:0] ent,
    input  logic          user,
    input  logic          write,
    input  logic          wp,
    output logic          allow,
    output logic          wable
);
    logic ro_user_page;

    always_comb begin
        ro_user_page = wp && ent[E_USER] && !ent[E_RW];
        if (user) begin
            allow = ent[E_USER] && (!write || ent[E_RW]);
            wable = ent[E_RW];
        end else begin
            allow = !(write && ro_user_page);
            wable = !ro_user_page;
        end
    end
endmodule

// File: rtl/pw_addr.sv
module pw_addr #(
    parameter int PG_OFF = 12,
    parameter int IDX_W  = 10
) (
    input  logic [PG_OFF+2*IDX_W-1:0] base,
    input  logic [PG_OFF+2*IDX_W-1:0] va,
    input  logic [PG_OFF+2*IDX_W-1:0] dir_ent,
    input  logic [PG_OFF+2*IDX_W-1:0] leaf_ent,
    output logic [PG_OFF+2*IDX_W-1:0] dir_addr,
    output logic [PG_OFF+2*IDX_W-1:0] tbl_addr,
    output logic [PG_OFF+2*IDX_W-1:0] big_pa,
    output logic [PG_OFF+2*IDX_W-1:0] small_pa
);
    localparam int AW     = PG_OFF + 2 * IDX_W;
    localparam int BIG_SH = PG_OFF + IDX_W;
    localparam logic [AW-1:0] FRAME = ~AW'((64'd1 << PG_OFF) - 64'd1);

    logic [AW-1:0] dir_idx4, tbl_idx4;

    assign dir_idx4 = {{(AW-IDX_W){1'b0}}, va[AW-1:BIG_SH]} << 2;
    assign tbl_idx4 = {{(AW-IDX_W){1'b0}}, va[BIG_SH-1:PG_OFF]} << 2;
    assign dir_addr = (base & FRAME) + dir_idx4;
    assign tbl_addr = (dir_ent & FRAME) + tbl_idx4;
    assign big_pa   = {leaf_ent[AW-1:BIG_SH], va[BIG_SH-1:0]};
    assign small_pa = {leaf_ent[AW-1:PG_OFF], va[PG_OFF-1:0]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
#(
    parameter int PG_OFF = 12,
    parameter int IDX_W  = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [PG_OFF+2*IDX_W-1:0]  req_vaddr,
    input  logic                       req_write,
    input  logic                       req_user,
    input  logic                       cfg_pg_en,
    input  logic                       cfg_wp,
    input  logic                       cfg_pse,
    input  logic [PG_OFF+2*IDX_W-1:0]  cfg_base,
    output logic                       rsp_valid,
    output logic                       rsp_fault,
    output logic [PG_OFF+2*IDX_W-1:0]  rsp_paddr,
    output logic                       rsp_writable,
    output logic [2:0]                 rsp_err,
    output logic [PG_OFF+2*IDX_W-1:0]  fault_addr,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [PG_OFF+2*IDX_W-1:0]  mem_addr,
    output logic [PG_OFF+2*IDX_W-1:0]  mem_wdata,
    input  logic                       mem_ack,
    input  logic [PG_OFF+2*IDX_W-1:0]  mem_rdata
);
    localparam int AW = PG_OFF + 2 * IDX_W;

    typedef struct packed {
        walk_st_e      st;
        logic [AW-1:0] va;
        logic          wr;
        logic          us;
        logic          wp;
        logic          pse;
        logic [AW-1:0] base;
        logic [AW-1:0] dir;
        logic [AW-1:0] wb;
        logic          big;
        logic          flt;
        logic [AW-1:0] pa;
        logic          wable;
        logic [2:0]    err;
        logic [AW-1:0] far;
    } walk_t;

    walk_t q, d;

    logic [AW-1:0] dir_addr, tbl_addr, big_pa, small_pa;
    logic          allow, wable;
    logic          go_flt, flt_prot;

    pw_addr #(.PG_OFF(PG_OFF), .IDX_W(IDX_W)) u_addr (
        .base    (q.base),
        .va      (q.va),
        .dir_ent (q.st == W_DIR_RD ? mem_rdata : q.dir),
        .leaf_ent(mem_rdata),
        .dir_addr(dir_addr),
        .tbl_addr(tbl_addr),
        .big_pa  (big_pa),
        .small_pa(small_pa)
    );

    pw_perm #(.EW(AW)) u_perm (
        .ent  (mem_rdata),
        .user (q.us),
        .write(q.wr),
        .wp   (q.wp),
        .allow(allow),
        .wable(wable)
    );

    always_comb begin
        d        = q;
        go_flt   = 1'b0;
        flt_prot = 1'b0;
        unique case (q.st)
            W_IDLE: begin
                if (req_valid) begin
                    d.va    = req_vaddr;
                    d.wr    = req_write;
                    d.us    = req_user;
                    d.wp    = cfg_wp;
                    d.pse   = cfg_pse;
                    d.base  = cfg_base;
                    d.flt   = 1'b0;
                    d.err   = 3'b000;
                    d.big   = 1'b0;
                    if (cfg_pg_en) begin
                        d.st = W_DIR_RD;
                    end else begin
                        d.pa    = req_vaddr;
                        d.wable = 1'b1;
                        d.st    = W_RESP;
                    end
                end
            end
            W_DIR_RD: begin
                if (mem_ack) begin
                    d.dir = mem_rdata;
                    if (!mem_rdata[E_PRES]) begin
                        go_flt = 1'b1;
                    end else if (!allow) begin
                        go_flt   = 1'b1;
                        flt_prot = 1'b1;
                    end else begin
                        d.big = mem_rdata[E_BIG] && q.pse;
                        if (d.big) begin
                            d.pa    = big_pa;
                            d.wable = wable;
                        end
                        d.wb = mem_rdata;
                        d.wb[E_ACC] = 1'b1;
                        if (d.big && q.wr) d.wb[E_DIRTY] = 1'b1;
                        if (!mem_rdata[E_ACC]) d.st = W_DIR_WR;
                        else                   d.st = d.big ? W_RESP : W_TBL_RD;
                    end
                end
            end
            W_DIR_WR: begin
                if (mem_ack) d.st = q.big ? W_RESP : W_TBL_RD;
            end
            W_TBL_RD: begin
                if (mem_ack) begin
                    if (!mem_rdata[E_PRES]) begin
                        go_flt = 1'b1;
                    end else if (!allow) begin
                        go_flt   = 1'b1;
                        flt_prot = 1'b1;
                    end else begin
                        d.pa    = small_pa;
                        d.wable = wable;
                        d.wb    = mem_rdata;
                        d.wb[E_ACC] = 1'b1;
                        if (q.wr) d.wb[E_DIRTY] = 1'b1;
                        if (!mem_rdata[E_ACC] || (q.wr && !mem_rdata[E_DIRTY]))
                            d.st = W_TBL_WR;
                        else
                            d.st = W_RESP;
                    end
                end
            end
            W_TBL_WR: begin
                if (mem_ack) d.st = W_RESP;
            end
            W_RESP: begin
                d.st = W_IDLE;
            end
            default: d.st = W_IDLE;
        endcase
        if (go_flt) begin
            d.flt   = 1'b1;
            d.err   = {q.us, q.wr, flt_prot};
            d.far   = q.va;
            d.pa    = '0;
            d.wable = 1'b0;
            d.st    = W_RESP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= W_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready    = (q.st == W_IDLE);
    assign rsp_valid    = (q.st == W_RESP);
    assign rsp_fault    = q.flt;
    assign rsp_paddr    = q.pa;
    assign rsp_writable = q.wable;
    assign rsp_err      = q.err;
    assign fault_addr   = q.far;
    assign mem_req      = (q.st == W_DIR_RD) || (q.st == W_DIR_WR) ||
                          (q.st == W_TBL_RD) || (q.st == W_TBL_WR);
    assign mem_we       = (q.st == W_DIR_WR) || (q.st == W_TBL_WR);
    assign mem_addr     = (q.st == W_TBL_RD || q.st == W_TBL_WR) ? tbl_addr : dir_addr;
    assign mem_wdata    = q.wb;
endmodule

// File: rtl/pw_checks.sv
module pw_checks #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_vaddr,
    input logic          cfg_pg_en,
    input logic          rsp_valid,
    input logic          rsp_fault,
    input logic [AW-1:0] rsp_paddr,
    input logic          rsp_writable,
    input logic [AW-1:0] fault_addr,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack
);
    // R12: a write is always part of a memory request
    p_we_in_req_r12: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    // R12: an unacknowledged request keeps its address
    p_hold_addr_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R12: response lasts one cycle and the walker is idle after it
    p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R12: no new request is taken while memory is busy
    p_busy_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    // R11: bypass answers in the next cycle with the same address
    p_bypass_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !cfg_pg_en) |=>
        (rsp_valid && !rsp_fault && rsp_writable && rsp_paddr == $past(req_vaddr) && !mem_req));

    // R3: a successful response leaves the fault address alone
    p_far_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> $stable(fault_addr));
endmodule

bind pt_walker pw_checks #(.AW(PG_OFF + 2 * IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .cfg_pg_en   (cfg_pg_en),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_paddr   (rsp_paddr),
    .rsp_writable(rsp_writable),
    .fault_addr  (fault_addr),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_vaddr = '0, cfg_base = '0;
    logic        cfg_pg_en = 1'b0, cfg_wp = 1'b0, cfg_pse = 1'b0;
    logic        req_ready, rsp_valid, rsp_fault, rsp_writable;
    logic [2:0]  rsp_err;
    logic [31:0] rsp_paddr, fault_addr, mem_addr, mem_wdata;
    logic        mem_req, mem_we;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int vectors = 0, miscompares = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_far = '0;
    bit done = 0;

    always #4 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
        .cfg_pg_en(cfg_pg_en), .cfg_wp(cfg_wp), .cfg_pse(cfg_pse), .cfg_base(cfg_base),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .rsp_writable(rsp_writable), .rsp_err(rsp_err), .fault_addr(fault_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic bit rights(input logic [31:0] e, input bit us, wr, wp);
        if (us) return e[2] && (!wr || e[1]);
        return !(wp && e[2] && wr && !e[1]);
    endfunction

    function automatic bit wflag(input logic [31:0] e, input bit us, wp);
        if (us) return e[1];
        return !(wp && e[2] && !e[1]);
    endfunction

    task automatic walk(input string tag, input logic [31:0] va, input bit wr, us, pg, wp, pse,
                        input logic [31:0] base);
        logic [31:0] qa[$], qd[$];
        bit          qw[$];
        bit          f = 0, prot = 0, wb = 0, dirty;
        logic [31:0] pa = '0, pde, pte, a;
        if (!pg) begin
            pa = va; wb = 1;
        end else begin
            a = (base & 32'hFFFF_F000) + ((va >> 22) << 2);
            pde = rd(a);
            qa.push_back(a); qw.push_back(0); qd.push_back(0);
            if (!pde[0]) f = 1;
            else if (!rights(pde, us, wr, wp)) begin f = 1; prot = 1; end
            else if (pde[7] && pse) begin
                if (!pde[5]) begin
                    qa.push_back(a); qw.push_back(1);
                    qd.push_back(pde | 32'h20 | (wr ? 32'h40 : 32'h0));
                end
                pa = {pde[31:22], va[21:0]};
                wb = wflag(pde, us, wp);
            end else begin
                if (!pde[5]) begin
                    qa.push_back(a); qw.push_back(1); qd.push_back(pde | 32'h20);
                end
                a = (pde & 32'hFFFF_F000) + ((va >> 10) & 32'hFFC);
                pte = rd(a);
                qa.push_back(a); qw.push_back(0); qd.push_back(0);
                if (!pte[0]) f = 1;
                else if (!rights(pte, us, wr, wp)) begin f = 1; prot = 1; end
                else begin
                    dirty = wr && !pte[6];
                    if (!pte[5] || dirty) begin
                        qa.push_back(a); qw.push_back(1);
                        qd.push_back(pte | 32'h20 | (dirty ? 32'h40 : 32'h0));
                    end
                    pa = {pte[31:12], va[11:0]};
                    wb = wflag(pte, us, wp);
                end
            end
        end
        if (f) exp_far = va;

        @(negedge clk);
        chk(tag, "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1; req_vaddr = va; req_write = wr; req_user = us;
        cfg_pg_en = pg; cfg_wp = wp; cfg_pse = pse; cfg_base = base;
        for (int i = 0; i <= qa.size(); i++) begin
            @(negedge clk);
            if (i == 0) req_valid = 0;
            if (i < qa.size()) begin
                chk(tag, "mem_req", 32'(mem_req), 32'd1);
                chk(tag, "mem_we", 32'(mem_we), 32'(qw[i]));
                chk(tag, "mem_addr", mem_addr, qa[i]);
                if (qw[i]) chk(tag, "mem_wdata", mem_wdata, qd[i]);
                chk(tag, "no early response", 32'(rsp_valid), 32'd0);
                mem_ack = 1;
                mem_rdata = rd(mem_addr);
                if (mem_we) mem[mem_addr] = mem_wdata;
            end else begin
                mem_ack = 0;
                chk(tag, "rsp_valid", 32'(rsp_valid), 32'd1);
                chk(tag, "no access at response", 32'(mem_req), 32'd0);
                chk(tag, "rsp_fault", 32'(rsp_fault), 32'(f));
                if (f) chk(tag, "rsp_err", 32'(rsp_err), {29'd0, us, wr, prot});
                else begin
                    chk(tag, "rsp_paddr", rsp_paddr, pa);
                    chk(tag, "rsp_writable", 32'(rsp_writable), 32'(wb));
                end
                chk(tag, "fault_addr", fault_addr, exp_far);
            end
        end
        @(negedge clk);
        chk(tag, "pulse ends (R12)", 32'(rsp_valid), 32'd0);
        chk(tag, "idle again (R12)", 32'(req_ready), 32'd1);
    endtask

    localparam logic [31:0] B = 32'h0000_1ABC;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R12: reset state
        chk("R12", "reset ready", 32'(req_ready), 32'd1);
        chk("R12", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R12", "reset mem_req", 32'(mem_req), 32'd0);
        chk("R12", "reset fault_addr", fault_addr, 32'd0);

        mem[32'h1004] = 32'h0000_2007;
        mem[32'h200C] = 32'h0012_3007;
        mem[32'h1008] = 32'h0;
        mem[32'h2010] = 32'h0000_5006;
        mem[32'h100C] = 32'h0000_3003;
        mem[32'h2014] = 32'h0006_0025;
        mem[32'h1010] = 32'h0C00_0087;
        mem[32'h0C00_0000] = 32'h0077_7001;
        mem[32'h1014] = 32'h0800_0083;

        walk("R11 bypass",         32'hDEAD_BEEF, 1, 0, 0, 1, 1, B);
        walk("R1 R2 R7 R8 first",  32'h0040_3123, 0, 0, 1, 0, 0, B);
        walk("R7 R8 no writeback", 32'h0040_3123, 0, 0, 1, 0, 0, B);
        walk("R8 R10 user write",  32'h0040_3123, 1, 1, 1, 0, 0, B);
        walk("R8 dirty kept",      32'h0040_3123, 1, 1, 1, 0, 0, B);
        walk("R3 dir absent",      32'h0080_0010, 1, 1, 1, 0, 0, B);
        walk("R3 table absent",    32'h0040_4000, 0, 1, 1, 0, 0, B);
        walk("R4 user on sup dir", 32'h00C0_0000, 0, 1, 1, 0, 0, B);
        walk("R4 user write ro",   32'h0040_5000, 1, 1, 1, 0, 0, B);
        walk("R5 wp fault",        32'h0040_5000, 1, 0, 1, 1, 0, B);
        walk("R5 R10 wp off",      32'h0040_5000, 1, 0, 1, 0, 0, B);
        walk("R10 sup read wp",    32'h0040_5000, 0, 0, 1, 1, 0, B);
        walk("R10 user read ro",   32'h0040_5000, 0, 1, 1, 0, 0, B);
        walk("R6 R9 big write",    32'h0100_0ABC, 1, 1, 1, 0, 1, B);
        walk("R9 big no wb",       32'h0100_0ABC, 0, 1, 1, 0, 1, B);
        walk("R6 big bit ignored", 32'h0100_0ABC, 0, 0, 1, 0, 0, B);
        walk("R9 big read",        32'h0140_0000, 0, 0, 1, 0, 1, B);
        walk("R11 after walks",    32'h1234_5678, 0, 1, 0, 0, 0, B);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule